// File: doc/BRIEF.md
# Memory-to-Memory Block Copy Engine

This block copies a programmed number of beats from a source address to a destination address over a simple request/response memory port. A controller writes a control word together with a start strobe. If the enable bit of that word is set and the transfer count is non-zero, the engine captures both 64-bit addresses, the beat width code and the stepping flags. It then runs read-then-write beats until the count is used up.

Each beat moves 1, 2, 4 or 8 bytes in little-endian lane order. The read data's low bytes are forwarded unchanged to the write. Each side's address either steps by the beat width after every beat or stays fixed, so the engine can drain a fixed-address source into a buffer or fill a fixed-address sink. A decrement flag makes the stepping sides walk downward instead of upward. While a copy runs, a busy flag is high and further start strobes are ignored. A one-cycle done pulse marks the end.

Top module: `dma_copy_engine`

## Requirements
- R1: During and after synchronous reset (`rst` high), busy, done, rd_req and wr_req are 0, beats_done is 0, and rd_addr, wr_addr and wr_data are 0.
- R2: A copy is launched only when `start` is high, bit 31 of ctl_word is 1, the engine is idle, and cnt_word[15:0] is non-zero. The beat count is cnt_word[15:0]; bits 31:16 are ignored.
- R3: A start with cnt_word[15:0] equal to 0, or with ctl_word bit 31 equal to 0, raises no request, no busy and no done.
- R4: ctl_word[26:25] is the width code W, and a beat moves 2**W bytes. rd_size and wr_size show W. wr_data holds the low 2**W bytes of the rd_data returned for that beat, and all higher bytes are 0.
- R5: When ctl_word bit 23 is 1, the read address of beat k is the source address plus k·2**W. When it is 0, every beat reads the source address.
- R6: When ctl_word bit 24 is 1, the write address of beat k is the destination address plus k·2**W. When it is 0, every beat writes the destination address.
- R7: When ctl_word bit 2 is 1, each side whose step bit is 1 moves down by 2**W per beat instead of up.
- R8: A read request is held, with a stable address, until the cycle in which rd_valid is high. The write request is raised in the next cycle and held, with stable address and data, until wr_ack. rd_req and wr_req are never high together.
- R9: busy rises in the cycle after the launching start and falls in the cycle after the last wr_ack. done is high for exactly that one cycle. beats_done counts the acknowledged writes of the current copy.
- R10: A start strobe while busy has no effect on the running copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Control-word write strobe |
| ctl_word | input | 32 | Control word: enable bit 31, width 26:25, destination step 24, source step 23, decrement 2 |
| cnt_word | input | 32 | Count word; only bits 15:0 are used |
| src_addr | input | 64 | Source start address |
| dst_addr | input | 64 | Destination start address |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle end-of-copy pulse |
| beats_done | output | 16 | Beats completed in the current or last copy |
| rd_req | output | 1 | Read request |
| rd_addr | output | 64 | Read address |
| rd_size | output | 2 | Read width code |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 64 | Read data, little-endian lanes |
| wr_req | output | 1 | Write request |
| wr_addr | output | 64 | Write address |
| wr_size | output | 2 | Write width code |
| wr_data | output | 64 | Write data, little-endian lanes |
| wr_ack | input | 1 | Write acknowledge |

## Verification
The hardest case to reach from the ports is a start strobe that arrives in the middle of a copy while a request is still waiting for its response. The bench slows its memory responder to several cycles of latency and pulses start, with different addresses and count, while the engine is waiting. The cycle-by-cycle reference model then shows that the original address sequence and beat count carry on unchanged. Zero-count starts with the upper count bits set, and starts with the enable bit clear, are watched for several idle cycles so that any stray request is caught.

// File: rtl/dma_copy_pkg.sv
package dma_copy_pkg;
  localparam int CTL_W        = 32;
  localparam int CTL_EN_BIT   = 31;
  localparam int CTL_WID_HI   = 26;
  localparam int CTL_WID_LO   = 25;
  localparam int CTL_DINC_BIT = 24;
  localparam int CTL_SINC_BIT = 23;
  localparam int CTL_DEC_BIT  = 2;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] stride,
  input  logic              step_en,
  input  logic              down,
  output logic [ADDR_W-1:0] nxt
);
  always_comb begin
    if (!step_en)  nxt = cur;
    else if (down) nxt = cur - stride;
    else           nxt = cur + stride;
  end
endmodule

// File: rtl/dma_lane_mask.sv
module dma_lane_mask #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        code,
  output logic [DATA_W-1:0] dout
);
  localparam int LANES = DATA_W / 8;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign dout[8*b +: 8] = (b < (1 << code)) ? din[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/dma_beat_ctrl.sv
module dma_beat_ctrl
  import dma_copy_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_req,
  input  logic [CNT_W-1:0] count,
  input  logic             rd_valid,
  input  logic             wr_ack,
  output logic             busy,
  output logic             done,
  output logic             rd_req,
  output logic             wr_req,
  output logic [CNT_W-1:0] beats,
  output logic             take_launch,
  output logic             take_read,
  output logic             take_write,
  output logic             last_beat
);
  phase_t           phase;
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] beats_nxt;

  assign beats_nxt   = beats + 1'b1;
  assign last_beat   = (beats_nxt == total_q);
  assign take_launch = (phase == PH_IDLE) && go_req && (count != '0);
  assign take_read   = (phase == PH_READ) && rd_valid;
  assign take_write  = (phase == PH_WRITE) && wr_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_req  <= 1'b0;
      wr_req  <= 1'b0;
      beats   <= '0;
      total_q <= '0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (take_launch) begin
          total_q <= count;
          beats   <= '0;
          busy    <= 1'b1;
          rd_req  <= 1'b1;
          phase   <= PH_READ;
        end
        PH_READ: if (take_read) begin
          rd_req <= 1'b0;
          wr_req <= 1'b1;
          phase  <= PH_WRITE;
        end
        PH_WRITE: if (take_write) begin
          wr_req <= 1'b0;
          beats  <= beats_nxt;
          if (last_beat) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            phase <= PH_IDLE;
          end else begin
            rd_req <= 1'b1;
            phase  <= PH_READ;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_one_req_R8: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> rd_req);
  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> wr_req);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_req_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_req || wr_req) |-> busy);
  assert_ignore_start_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && go_req) |=> $stable(total_q));
endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
  import dma_copy_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CTL_W-1:0]  ctl_word,
  input  logic [31:0]       cnt_word,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  beats_done,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_size,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [1:0]        wr_size,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack
);
  logic              go_req, take_launch, take_read, take_write, last_beat;
  logic [1:0]        size_q;
  logic              sinc_q, dinc_q, dec_q;
  logic [ADDR_W-1:0] src_q, dst_q, src_next, dst_next, stride;
  logic [ADDR_W-1:0] rd_addr_q, wr_addr_q;
  logic [DATA_W-1:0] wr_data_q, lane_data;
  logic              unused_cfg;

  assign unused_cfg = ^{cnt_word[31:CNT_W], ctl_word[30:27], ctl_word[22:3], ctl_word[1:0]};
  assign go_req     = start && ctl_word[CTL_EN_BIT];
  assign stride     = ADDR_W'(1) << size_q;

  dma_beat_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .go_req(go_req), .count(cnt_word[CNT_W-1:0]),
    .rd_valid(rd_valid), .wr_ack(wr_ack), .busy(busy), .done(done),
    .rd_req(rd_req), .wr_req(wr_req), .beats(beats_done),
    .take_launch(take_launch), .take_read(take_read),
    .take_write(take_write), .last_beat(last_beat)
  );

  dma_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
    .cur(src_q), .stride(stride), .step_en(sinc_q), .down(dec_q), .nxt(src_next)
  );
  dma_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
    .cur(dst_q), .stride(stride), .step_en(dinc_q), .down(dec_q), .nxt(dst_next)
  );
  dma_lane_mask #(.DATA_W(DATA_W)) u_mask (
    .din(rd_data), .code(size_q), .dout(lane_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q    <= '0;
      sinc_q    <= 1'b0;
      dinc_q    <= 1'b0;
      dec_q     <= 1'b0;
      src_q     <= '0;
      dst_q     <= '0;
      rd_addr_q <= '0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      if (take_launch) begin
        size_q    <= ctl_word[CTL_WID_HI:CTL_WID_LO];
        sinc_q    <= ctl_word[CTL_SINC_BIT];
        dinc_q    <= ctl_word[CTL_DINC_BIT];
        dec_q     <= ctl_word[CTL_DEC_BIT];
        src_q     <= src_addr;
        dst_q     <= dst_addr;
        rd_addr_q <= src_addr;
      end
      if (take_read) begin
        wr_addr_q <= dst_q;
        wr_data_q <= lane_data;
      end
      if (take_write) begin
        src_q <= src_next;
        dst_q <= dst_next;
        if (!last_beat) rd_addr_q <= src_next;
      end
    end
  end

  assign rd_addr = rd_addr_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign rd_size = size_q;
  assign wr_size = size_q;

  assert_rd_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> $stable(rd_addr));
  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> ($stable(wr_data) && $stable(wr_addr)));
  assert_fixed_src_R5: assert property (@(posedge clk) disable iff (rst)
    (take_write && !sinc_q) |=> (src_q == $past(src_q)));
  assert_fixed_dst_R6: assert property (@(posedge clk) disable iff (rst)
    (take_write && !dinc_q) |=> (dst_q == $past(dst_q)));
  assert_size_steady_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && wr_req) |=> $stable(wr_size));
endmodule

// File: tb/dma_copy_engine_bench.sv
`timescale 1ns/1ps
module dma_copy_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] ctl_word = '0, cnt_word = '0;
  logic [63:0] src_addr = '0, dst_addr = '0;
  logic        busy, done, rd_req, wr_req;
  logic [15:0] beats_done;
  logic [63:0] rd_addr, wr_addr, wr_data;
  logic [1:0]  rd_size, wr_size;
  logic        rd_valid = 1'b0, wr_ack = 1'b0;
  logic [63:0] rd_data = '0;

  always #2 clk = ~clk;

  dma_copy_engine u_dma_copy_engine (
    .clk(clk), .rst(rst), .start(start), .ctl_word(ctl_word), .cnt_word(cnt_word),
    .src_addr(src_addr), .dst_addr(dst_addr), .busy(busy), .done(done),
    .beats_done(beats_done), .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_data(wr_data), .wr_ack(wr_ack)
  );

  int tests = 0, fails = 0;
  int lat = 0, rcnt = 0, wcnt = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    return {a[31:0] ^ 32'hA5C3_0F1E, a[31:0] + 32'h1357_9BDF};
  endfunction

  function automatic logic [63:0] lanes(input logic [63:0] d, input int w);
    logic [63:0] r = '0;
    for (int j = 0; j < 8; j++) if (j < (1 << w)) r[8*j +: 8] = d[8*j +: 8];
    return r;
  endfunction

  function automatic logic [31:0] mk_ctl(input bit en, input int w, input bit dinc,
                                         input bit sinc, input bit dec);
    logic [31:0] c = '0;
    c[31] = en; c[26:25] = w[1:0]; c[24] = dinc; c[23] = sinc; c[2] = dec;
    return c;
  endfunction

  // Behavioural reference: phase 0 idle, 1 waiting read, 2 waiting write
  int          m_ph = 0, m_w = 0, m_beats = 0;
  bit          m_busy = 0, m_done = 0;
  logic [63:0] qs[$], qd[$];

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_busy = 0; m_done = 0; m_beats = 0; m_w = 0;
      qs.delete(); qd.delete();
    end else begin
      m_done = 0;
      case (m_ph)
        0: if (start && ctl_word[31] && cnt_word[15:0] != 0) begin
          m_w = int'(ctl_word[26:25]);
          m_beats = 0;
          for (int k = 0; k < int'(cnt_word[15:0]); k++) begin
            logic [63:0] off;
            off = 64'(k) << m_w;
            qs.push_back(!ctl_word[23] ? src_addr : ctl_word[2] ? src_addr - off : src_addr + off);
            qd.push_back(!ctl_word[24] ? dst_addr : ctl_word[2] ? dst_addr - off : dst_addr + off);
          end
          m_busy = 1; m_ph = 1;
        end
        1: if (rd_valid) m_ph = 2;
        default: if (wr_ack) begin
          void'(qs.pop_front()); void'(qd.pop_front());
          m_beats++;
          if (qs.size() == 0) begin m_ph = 0; m_busy = 0; m_done = 1; end
          else m_ph = 1;
        end
      endcase
    end
  end

  // Memory responder with programmable latency
  always @(negedge clk) begin
    rd_valid = 1'b0; wr_ack = 1'b0;
    if (rd_req) begin
      if (rcnt >= lat) begin rd_valid = 1'b1; rd_data = mem_word(rd_addr); rcnt = 0; end
      else rcnt++;
    end
    if (wr_req) begin
      if (wcnt >= lat) begin wr_ack = 1'b1; wcnt = 0; end
      else wcnt++;
    end
  end

  // Per-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      chk("R9 busy", 64'(busy), 64'(m_busy));
      chk("R9 done", 64'(done), 64'(m_done));
      chk("R9 beats_done", 64'(beats_done), 64'(m_beats));
      chk("R8 rd_req", 64'(rd_req), 64'(m_ph == 1));
      chk("R8 wr_req", 64'(wr_req), 64'(m_ph == 2));
      if (m_ph == 1) begin
        chk("R5 rd_addr", rd_addr, qs[0]);
        chk("R4 rd_size", 64'(rd_size), 64'(m_w));
      end
      if (m_ph == 2) begin
        chk("R6 wr_addr", wr_addr, qd[0]);
        chk("R4 wr_size", 64'(wr_size), 64'(m_w));
        chk("R4 wr_data", wr_data, lanes(mem_word(qs[0]), m_w));
      end
    end
  end

  task automatic pulse_start(input logic [63:0] s, input logic [63:0] d,
                             input logic [31:0] c, input logic [31:0] n);
    @(negedge clk);
    src_addr = s; dst_addr = d; ctl_word = c; cnt_word = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input string tag, input logic [63:0] s, input logic [63:0] d,
                     input logic [31:0] c, input logic [31:0] n, input int l);
    int f0 = fails;
    lat = l;
    pulse_start(s, d, c, n);
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk({tag, " no mismatch in copy"}, 64'(fails - f0), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 0); chk("R1 done", 64'(done), 0);
    chk("R1 reqs", 64'({rd_req, wr_req}), 0); chk("R1 beats", 64'(beats_done), 0);
    chk("R1 rd_addr", rd_addr, 0); chk("R1 wr_addr", wr_addr, 0); chk("R1 wr_data", wr_data, 0);
    @(negedge clk); rst = 1'b0;

    run("R4 R5 R6 4-byte both stepping", 64'h0000_0001_0000_1000, 64'h0000_0002_0000_2000,
        mk_ctl(1, 2, 1, 1, 0), 32'd3, 0);
    run("R5 byte fixed source", 64'h0000_0000_0000_0333, 64'h0000_0000_0000_4000,
        mk_ctl(1, 0, 1, 0, 0), 32'd4, 2);
    run("R6 8-byte fixed destination", 64'h0000_0000_0000_8000, 64'h0000_0000_0000_9008,
        mk_ctl(1, 3, 0, 1, 0), 32'd2, 1);
    run("R7 decrement 2-byte", 64'h0000_0000_0000_1000, 64'h0000_0000_0000_2000,
        mk_ctl(1, 1, 1, 1, 1), 32'd3, 0);

    // R3 zero count with upper bits set: nothing happens
    lat = 0;
    pulse_start(64'h10, 64'h20, mk_ctl(1, 2, 1, 1, 0), 32'h0001_0000);
    repeat (6) @(negedge clk);
    chk("R3 zero count busy", 64'(busy), 0);
    chk("R3 zero count no request", 64'({rd_req, wr_req}), 0);
    // R3 enable bit clear: nothing happens
    pulse_start(64'h10, 64'h20, mk_ctl(0, 2, 1, 1, 0), 32'd5);
    repeat (6) @(negedge clk);
    chk("R3 enable clear busy", 64'(busy), 0);
    chk("R3 enable clear beats", 64'(beats_done), 64'd3);

    // R2 upper count bits ignored: 0x10002 gives two beats
    run("R2 upper count ignored", 64'h0000_0000_0000_A000, 64'h0000_0000_0000_B000,
        mk_ctl(1, 2, 1, 1, 0), 32'h0001_0002, 0);
    chk("R2 beat count", 64'(beats_done), 64'd2);

    // R10 start while busy with slow memory
    begin
      int f0;
      f0 = fails;
      lat = 4;
      pulse_start(64'h0000_0000_0000_C000, 64'h0000_0000_0000_D000, mk_ctl(1, 2, 1, 1, 0), 32'd3);
      repeat (3) @(negedge clk);
      pulse_start(64'h0000_0000_0000_E000, 64'h0000_0000_0000_F000, mk_ctl(1, 0, 0, 0, 0), 32'd9);
      while (m_busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R10 restart ignored", 64'(fails - f0), 64'd0);
      chk("R10 beat count", 64'(beats_done), 64'd3);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule